// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command, address and control pins of a four-bank single-data-rate SDRAM from reset until the memory can accept normal traffic. After reset it holds the pins at NOP for a power-up wait sized from the clock frequency. It then precharges every bank, issues a run of auto-refresh commands, and loads the mode register with a value fixed at build time. Every command is followed by NOP cycles sized from the device timing parameters.

Once the last gap has elapsed, a sticky ready flag tells the surrounding controller that it may take over the pins. Every pin comes from a flop that changes on the rising clock edge, because the memory samples its inputs on that edge. An active-low reset asserts at once. It is released through a two-stage synchronizer. Asserting it at any point returns the pins to their idle state and restarts the whole sequence.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and for the first two rising edges after it rises (the reset synchronizer), the pins show NOP. NOP means {cs_n,ras_n,cas_n,we_n} = 4'b0111, with address 0, bank 0 and `init_done` low.
- R2: `sd_cke` and every bit of `sd_dqm` are high at all times, including during reset.
- R3: WAIT_CYC is ceil(WAIT_US × CLK_FREQ_KHZ / 1000). The pins stay at NOP until the PRECHARGE, which appears right after rising edge WAIT_CYC+2 counted from the release of `rst_n`.
- R4: PRECHARGE is encoded 4'b0010, with address bit 10 high, all other address bits 0 and bank 0. It is issued exactly once per sequence.
- R5: The first AUTO REFRESH (4'b0001, address 0) is issued T_RP edges after the PRECHARGE.
- R6: The number of AUTO REFRESH commands is max(REFRESH_COUNT, 8). Consecutive refreshes are T_RC edges apart.
- R7: LOAD MODE (4'b0000) is issued T_RC edges after the last refresh, with MODE_VALUE on the address pins and bank 0.
- R8: Every cycle after reset that carries none of the commands above shows NOP with address 0.
- R9: `init_done` rises T_MRD edges after the LOAD MODE and stays high while `rst_n` stays high. From then on the pins stay at NOP.
- R10: Pulling `rst_n` low between clock edges at once returns every output to its reset value, including a raised `init_done`. On release, the full sequence runs again from the start of the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| sd_cke | output | 1 | Clock enable to the memory, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address, always 0 |
| sd_addr | output | ADDR_W | Address bus: A10 for precharge-all, mode value for LOAD MODE |
| sd_dqm | output | DQM_W | Data mask lanes, held high |
| init_done | output | 1 | Sticky flag: initialization finished |

## Verification
The bench runs two configurations side by side. The default one has a wait of ten thousand cycles and multi-cycle gaps. The other has a frequency that makes the wait round up, a refresh count below eight, and one-cycle precharge and mode gaps. That second configuration catches a design that truncates the wait, honours a refresh count below the floor, or slips a command by one cycle when a gap collapses to a single edge. A reset asserted mid-refresh and off the clock edge must clear the pins, and the ready flag of the configuration that has already finished, before the next edge. A design that resets only synchronously, or resumes the sequence instead of restarting it, fails that check. A per-cycle reference comparison catches an off-by-one anywhere in the schedule, a missing A10 on the precharge, a wrong mode value, and a flag that rises early or drops again.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command encoding on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    PH_WAIT    = 3'd0,
    PH_PRE_GAP = 3'd1,
    PH_REF_GAP = 3'd2,
    PH_LMR_GAP = 3'd3,
    PH_READY   = 3'd4
  } init_phase_e;

  localparam int RST_SYNC_STAGES = 2;
  localparam int MIN_REFRESHES   = 8;
  localparam int AUTO_PRE_BIT    = 10;

  function automatic int ceil_div(input longint num, input longint den);
    return int'((num + den - 1) / den);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int             W         = 8,
  parameter logic [W-1:0]   RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_en || (cnt_q != '0);
    if (load_en) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RESET_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_ref_counter.sv
module sdram_ref_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_en,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int REF_W = 4,
  parameter int REF_N = 8,
  parameter int T_RP  = 3,
  parameter int T_RC  = 9,
  parameter int T_MRD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gap_expired,
  input  logic [REF_W-1:0] refs_issued,
  output sd_cmd_e          cmd_next,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             ref_inc,
  output logic             done_set
);

  localparam logic [TMR_W-1:0] RP_LOAD  = TMR_W'(T_RP - 1);
  localparam logic [TMR_W-1:0] RC_LOAD  = TMR_W'(T_RC - 1);
  localparam logic [TMR_W-1:0] MRD_LOAD = TMR_W'(T_MRD - 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_N);

  init_phase_e ph_q;
  init_phase_e ph_d;

  always_comb begin
    ph_d     = ph_q;
    cmd_next = CMD_NOP;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_inc  = 1'b0;
    done_set = 1'b0;
    unique case (ph_q)
      PH_WAIT: begin
        if (gap_expired) begin
          cmd_next = CMD_PRE;
          tmr_load = 1'b1;
          tmr_val  = RP_LOAD;
          ph_d     = PH_PRE_GAP;
        end
      end
      PH_PRE_GAP: begin
        if (gap_expired) begin
          cmd_next = CMD_REF;
          tmr_load = 1'b1;
          tmr_val  = RC_LOAD;
          ref_inc  = 1'b1;
          ph_d     = PH_REF_GAP;
        end
      end
      PH_REF_GAP: begin
        if (gap_expired) begin
          tmr_load = 1'b1;
          if (refs_issued == REF_LAST) begin
            cmd_next = CMD_LMR;
            tmr_val  = MRD_LOAD;
            ph_d     = PH_LMR_GAP;
          end else begin
            cmd_next = CMD_REF;
            tmr_val  = RC_LOAD;
            ref_inc  = 1'b1;
          end
        end
      end
      PH_LMR_GAP: begin
        if (gap_expired) begin
          done_set = 1'b1;
          ph_d     = PH_READY;
        end
      end
      PH_READY: begin
        ph_d = PH_READY;
      end
      default: begin
        ph_d = PH_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_WAIT;
    end else begin
      ph_q <= ph_d;
    end
  end

endmodule

// File: rtl/sdram_pin_drv.sv
module sdram_pin_drv
  import sdram_init_pkg::*;
#(
  parameter int              ADDR_W     = 13,
  parameter int              BA_W       = 2,
  parameter int              DQM_W      = 2,
  parameter logic [ADDR_W-1:0] MODE_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sd_cmd_e           cmd_next,
  input  logic              done_set,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);

  sd_cmd_e           cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic [BA_W-1:0]   ba_q;
  logic              cke_q;
  logic [DQM_W-1:0]  dqm_q;
  logic              done_q;
  logic              done_d;

  always_comb begin
    addr_d = '0;
    unique case (cmd_next)
      CMD_PRE: addr_d[AUTO_PRE_BIT] = 1'b1;
      CMD_LMR: addr_d = MODE_VALUE;
      default: addr_d = '0;
    endcase
    done_d = done_q | done_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      cke_q  <= 1'b1;
      dqm_q  <= '1;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_next;
      addr_q <= addr_d;
      ba_q   <= '0;
      cke_q  <= 1'b1;
      dqm_q  <= '1;
      done_q <= done_d;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr   = addr_q;
  assign sd_ba     = ba_q;
  assign sd_cke    = cke_q;
  assign sd_dqm    = dqm_q;
  assign init_done = done_q;

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int                CLK_FREQ_KHZ  = 100000,
  parameter int                WAIT_US       = 100,
  parameter int                REFRESH_COUNT = 8,
  parameter int                T_RP          = 3,
  parameter int                T_RC          = 9,
  parameter int                T_MRD         = 2,
  parameter int                ADDR_W        = 13,
  parameter int                BA_W          = 2,
  parameter int                DQM_W         = 2,
  parameter logic [ADDR_W-1:0] MODE_VALUE    = 13'h0033
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);

  localparam int WAIT_CYC = ceil_div(longint'(WAIT_US) * longint'(CLK_FREQ_KHZ), 1000);
  localparam int REF_N    = imax(REFRESH_COUNT, MIN_REFRESHES);
  localparam int TMR_MAX  = imax(imax(WAIT_CYC, T_RP), imax(T_RC, T_MRD));
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int REF_W    = $clog2(REF_N + 1);
  localparam logic [TMR_W-1:0] WAIT_LOAD = TMR_W'(WAIT_CYC - 1);

  logic             srst_n;
  logic             gap_expired;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             ref_inc;
  logic [REF_W-1:0] refs_issued;
  logic             done_set;
  sd_cmd_e          cmd_next;

  sdram_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  sdram_gap_timer #(.W(TMR_W), .RESET_VAL(WAIT_LOAD)) u_gap_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load_en  (tmr_load),
    .load_val (tmr_val),
    .expired  (gap_expired)
  );

  sdram_ref_counter #(.W(REF_W)) u_ref_counter (
    .clk    (clk),
    .rst_n  (srst_n),
    .inc_en (ref_inc),
    .count  (refs_issued)
  );

  sdram_init_fsm #(
    .TMR_W (TMR_W),
    .REF_W (REF_W),
    .REF_N (REF_N),
    .T_RP  (T_RP),
    .T_RC  (T_RC),
    .T_MRD (T_MRD)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (srst_n),
    .gap_expired (gap_expired),
    .refs_issued (refs_issued),
    .cmd_next    (cmd_next),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .ref_inc     (ref_inc),
    .done_set    (done_set)
  );

  sdram_pin_drv #(
    .ADDR_W     (ADDR_W),
    .BA_W       (BA_W),
    .DQM_W      (DQM_W),
    .MODE_VALUE (MODE_VALUE)
  ) u_pin_drv (
    .clk       (clk),
    .rst_n     (srst_n),
    .cmd_next  (cmd_next),
    .done_set  (done_set),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .sd_dqm    (sd_dqm),
    .init_done (init_done)
  );

endmodule

// File: rtl/sdram_pwrup_chk.sv
module sdram_pwrup_chk #(
  parameter int                WAIT_CYC   = 10000,
  parameter int                REF_N      = 8,
  parameter int                ADDR_W     = 13,
  parameter int                BA_W       = 2,
  parameter int                DQM_W      = 2,
  parameter logic [ADDR_W-1:0] MODE_VALUE = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic [DQM_W-1:0]  dqm,
  input logic              init_done
);

  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  logic is_nop, is_pre, is_ref, is_lmr;
  assign is_nop = (cmd == 4'b0111);
  assign is_pre = (cmd == 4'b0010);
  assign is_ref = (cmd == 4'b0001);
  assign is_lmr = (cmd == 4'b0000);

  int nop_seen, pre_seen, ref_seen, lmr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nop_seen <= 0;
      pre_seen <= 0;
      ref_seen <= 0;
      lmr_seen <= 0;
    end else begin
      if (is_nop && pre_seen == 0) nop_seen <= nop_seen + 1;
      if (is_pre) pre_seen <= pre_seen + 1;
      if (is_ref) ref_seen <= ref_seen + 1;
      if (is_lmr) lmr_seen <= lmr_seen + 1;
    end
  end

  assert_cke_dqm_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cke && (&dqm));

  assert_legal_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop || is_pre || is_ref || is_lmr);

  assert_pre_after_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (nop_seen >= WAIT_CYC));

  assert_pre_all_banks_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (addr[10] && pre_seen == 0 && ba == '0));

  assert_ref_after_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (pre_seen == 1 && lmr_seen == 0));

  assert_lmr_after_refs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_lmr |-> (ref_seen == REF_N && ref_seen >= 8));

  assert_lmr_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_lmr |-> (addr == MODE_VALUE && ba == '0 && lmr_seen == 0));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_done_after_lmr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (lmr_seen == 1));

  assert_nop_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);

endmodule

bind sdram_pwrup_seq sdram_pwrup_chk #(
  .WAIT_CYC   (WAIT_CYC),
  .REF_N      (REF_N),
  .ADDR_W     (ADDR_W),
  .BA_W       (BA_W),
  .DQM_W      (DQM_W),
  .MODE_VALUE (MODE_VALUE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (sd_cke),
  .cs_n      (sd_cs_n),
  .ras_n     (sd_ras_n),
  .cas_n     (sd_cas_n),
  .we_n      (sd_we_n),
  .ba        (sd_ba),
  .addr      (sd_addr),
  .dqm       (sd_dqm),
  .init_done (init_done)
);

// File: tb/sdram_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_tb_top;

  // Configuration A (defaults) and B (rounded wait, clamped refresh count, 1-cycle gaps)
  localparam int A_KHZ = 100000, A_US = 100, A_REF = 8, A_RP = 3, A_RC = 9, A_MRD = 2;
  localparam logic [12:0] A_MODE = 13'h0033;
  localparam int B_KHZ = 33333, B_US = 1, B_REF = 3, B_RP = 1, B_RC = 2, B_MRD = 1;
  localparam logic [12:0] B_MODE = 13'h0027;

  localparam int A_WAIT = (A_US * A_KHZ + 999) / 1000;
  localparam int B_WAIT = (B_US * B_KHZ + 999) / 1000;
  localparam int A_NREF = (A_REF < 8) ? 8 : A_REF;
  localparam int B_NREF = (B_REF < 8) ? 8 : B_REF;
  localparam int A_END  = A_WAIT + 2 + A_RP + A_NREF * A_RC + A_MRD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0]  a_ba, a_dqm;
  logic [12:0] a_addr;
  logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0]  b_ba, b_dqm;
  logic [12:0] b_addr;

  sdram_pwrup_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
    .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_ba(a_ba), .sd_addr(a_addr),
    .sd_dqm(a_dqm), .init_done(a_done)
  );

  sdram_pwrup_seq #(
    .CLK_FREQ_KHZ(B_KHZ), .WAIT_US(B_US), .REFRESH_COUNT(B_REF),
    .T_RP(B_RP), .T_RC(B_RC), .T_MRD(B_MRD), .MODE_VALUE(B_MODE)
  ) dut_small_i (
    .clk(clk), .rst_n(rst_n), .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
    .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_ba(b_ba), .sd_addr(b_addr),
    .sd_dqm(b_dqm), .init_done(b_done)
  );

  int checks = 0;
  int errors = 0;
  int k = 0;          // rising edges since rst_n release
  bit monitor_on = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  // Behavioural reference: expected pins after edge kk
  task automatic model(input int kk, input int wait_c, input int trp, input int trc,
                       input int tmrd, input int nref, input logic [12:0] mode,
                       output logic [3:0] cmd, output logic [12:0] addr,
                       output logic done, output string tag);
    int p, m;
    p = wait_c + 2;
    m = p + trp + nref * trc;
    cmd = 4'b0111; addr = '0;
    done = (kk > 0) && (kk >= m + tmrd);
    if (kk < 3)      tag = "R1";
    else if (kk < p) tag = "R3";
    else if (done)   tag = "R9";
    else             tag = "R8";
    if (kk > 0 && kk == p) begin
      cmd = 4'b0010; addr = 13'h0400; tag = "R4";
    end
    for (int i = 0; i < nref; i++) begin
      if (kk > 0 && kk == p + trp + i * trc) begin
        cmd = 4'b0001; tag = (i == 0) ? "R5" : "R6";
      end
    end
    if (kk > 0 && kk == m) begin
      cmd = 4'b0000; addr = mode; tag = "R7";
    end
  endtask

  task automatic check(input string who, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s %s at edge %0d: actual %h expected %h", tag, who, what, k, act, exp);
    end
  endtask

  task automatic check_dut(input string who, input string force_tag, input int kk,
                           input int wait_c, input int trp, input int trc, input int tmrd,
                           input int nref, input logic [12:0] mode,
                           input logic [3:0] cmd_o, input logic [12:0] addr_o,
                           input logic [1:0] ba_o, input logic done_o,
                           input logic cke_o, input logic [1:0] dqm_o);
    logic [3:0] e_cmd; logic [12:0] e_addr; logic e_done; string tag;
    model(kk, wait_c, trp, trc, tmrd, nref, mode, e_cmd, e_addr, e_done, tag);
    if (force_tag != "") tag = force_tag;
    check(who, tag, "cmd", {12'h0, cmd_o}, {12'h0, e_cmd});
    check(who, tag, "addr", {3'h0, addr_o}, {3'h0, e_addr});
    check(who, tag, "bank", {14'h0, ba_o}, 16'h0);
    check(who, (force_tag != "") ? force_tag : ((kk == 0) ? "R1" : "R9"), "init_done",
          {15'h0, done_o}, {15'h0, e_done});
    check(who, "R2", "cke_dqm", {13'h0, cke_o, dqm_o}, 16'h0007);
  endtask

  task automatic check_both(input string force_tag);
    check_dut("A", force_tag, k, A_WAIT, A_RP, A_RC, A_MRD, A_NREF, A_MODE,
              {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba, a_done, a_cke, a_dqm);
    check_dut("B", force_tag, k, B_WAIT, B_RP, B_RC, B_MRD, B_NREF, B_MODE,
              {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba, b_done, b_cke, b_dqm);
  endtask

  always @(negedge clk) begin
    if (monitor_on) check_both("");
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired at edge %0d", k);
      summary();
    end
  end

  initial begin
    monitor_on = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;                              // R1, R3: first sequence
    while (k < A_END + 10) @(negedge clk);     // both configurations reach ready (R9)
    // R10: second release, then reset off the edge in the middle of the refresh run
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (k < A_WAIT + 2 + A_RP + 2 * A_RC + 1) @(negedge clk);
    @(posedge clk); #2;
    monitor_on = 1'b0;
    rst_n = 1'b0;
    #1;
    check_both("R10");                         // B had init_done high; must be cleared
    monitor_on = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                              // R10: sequence restarts from the wait
    while (k < A_END + 10) @(negedge clk);
    finished = 1'b1;
    summary();
  end

endmodule